// File: doc/BRIEF.md
# Flash Erase and Program Command Controller

This block sits on the special-function-register bus of a small microcontroller and decides which modifications reach the on-chip flash array. Software arms an erase by writing a page number or setting a whole-array enable, then writes a magic byte to the command register. The block turns that into a single operation request to the flash macro, provided a 4-bit key register holds 2 and the flash is idle. Every arming bit is spent by the erase it enables, so each new erase has to be armed again.

Byte programming uses the normal data-space store path. While the program-enable bit is set, the next store becomes a flash program request, and the bit then clears itself. Software can turn on deferred writes. If the external compute engine is also enabled, the request waits in a one-entry buffer and is sent to the flash only when the engine's busy line falls. A read-only flag shows when that buffer is occupied. Status bits report whether an operation is in flight and whether external debug and SPI ports may read or write the flash.

Register map (`reg_addr`):
- 0 is the command register. It reads back the last byte written.
- 1 is the page register, bits 5:0.
- 2 is the control register: bit 0 is the whole-array erase enable, bit 1 is the program enable, bit 2 is the deferred-write enable, and bits 7:4 are the key.
- 3 is the status register, read-only: bit 0 is pending, bit 1 is busy, bit 2 is read-ok, bit 3 is write-ok, and the upper bits read 0.

Flash operation codes on `fl_op` are 1 for page erase, 2 for whole-array erase and 3 for byte program.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Writing 0x55 to register 0 issues a page erase (`fl_op`=1) with `fl_addr` = page << 10. This happens only when the key is 2, the page register has been written since the last erase, and no operation is in flight.
- R2: Writing 0xAA to register 0 issues a whole-array erase (`fl_op`=2, `fl_addr`=0). This happens only when the key is 2, control bit 0 is set, `dbg_en` is high, and the flash is idle.
- R3: Register 0 resets to 0x00 and reads back any byte written to it. Any value other than 0x55 or 0xAA issues no operation.
- R4: An issued erase clears both the page arming and control bit 0. A second command issues nothing until the relevant register is written again.
- R5: With the key not equal to 2, no erase and no program request is accepted.
- R6: When control bit 1 is set and the key is 2, a store issues a program operation (`fl_op`=3) carrying the store's address and data. Any store seen while bit 1 is set clears bit 1.
- R7: A write to register 2 leaves bit 1 unchanged while `irq_en` is high.
- R8: When control bit 2 and `eng_en` are both high, a program request is held and issued after `eng_busy` goes from 1 to 0. Status bit 0 is set while the request is held. Otherwise a program request issues immediately.
- R9: A program request that arrives while status bit 0 is set is dropped. The held request is unchanged.
- R10: Status bit 2 equals the inverse of `secure`. Status bit 3 is high when the key is 2 and `secure` is low. Status bit 1 is high from `fl_start` until `fl_done`, and erase commands written during that time are ignored.
- R11: `fl_start` is a one-cycle pulse, and no new operation starts while one is awaiting `fl_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| st_valid | input | 1 | Data-space store strobe |
| st_addr | input | 16 | Store address |
| st_data | input | 8 | Store data |
| irq_en | input | 1 | Interrupts enabled; locks control bit 1 |
| dbg_en | input | 1 | Debug port enabled; needed for whole-array erase |
| secure | input | 1 | Security lock |
| eng_en | input | 1 | Compute engine enabled |
| eng_busy | input | 1 | Compute engine busy |
| fl_start | output | 1 | Operation start pulse to flash |
| fl_op | output | 2 | Operation code |
| fl_addr | output | 16 | Operation address |
| fl_data | output | 8 | Program data |
| fl_done | input | 1 | Operation complete from flash |

## Verification
Several rules are checked on every cycle by assertions:
- no start while an operation is outstanding;
- every erase start preceded by the key and the matching arming bit;
- arming spent after a page erase;
- program enable never rising while interrupts are on;
- the held request surviving a second request.

Only the bench scenarios can show the rest:
- the exact address and data of each operation;
- that wrong magic bytes, missing arming or a busy flash produce no operation at all;
- that a deferred write leaves only on the busy line's falling edge and not before.

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl #(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int PW       = 6,
  parameter int PAGE_LSB = 10,
  parameter int KEY      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          irq_en,
  input  logic          dbg_en,
  input  logic          secure,
  input  logic          eng_en,
  input  logic          eng_busy,
  output logic          fl_start,
  output logic [1:0]    fl_op,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_data,
  input  logic          fl_done
);
  localparam logic [1:0] OP_PAGE = 2'd1, OP_MASS = 2'd2, OP_PROG = 2'd3;
  localparam logic [3:0] KEYV = 4'(KEY);

  logic [7:0]    cmd_q;
  logic [PW-1:0] page_q;
  logic          page_arm, mass_en, pwe, defer_en;
  logic [3:0]    key_q;
  logic          active, pend, fired, eng_busy_q;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;

  wire key_ok   = (key_q == KEYV);
  wire wr_cmd   = reg_wr && reg_addr == 2'd0;
  wire wr_page  = reg_wr && reg_addr == 2'd1;
  wire wr_ctl   = reg_wr && reg_addr == 2'd2;
  wire pg_er    = wr_cmd && reg_wdata == 8'h55 && key_ok && page_arm && !active;
  wire ms_er    = wr_cmd && reg_wdata == 8'hAA && key_ok && mass_en && dbg_en && !active;
  wire prog_req = st_valid && pwe && key_ok;
  wire to_buf   = prog_req && defer_en && eng_en;
  wire fell     = eng_busy_q && !eng_busy;
  wire rel      = pend && (fell || fired) && !active;
  wire imm      = prog_req && !to_buf && !active;
  wire do_er    = !rel && (pg_er || ms_er);
  wire do_pg    = !rel && !pg_er && !ms_er && imm;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = cmd_q;
      2'd1:    reg_rdata = 8'(page_q);
      2'd2:    reg_rdata = {key_q, 1'b0, defer_en, pwe, mass_en};
      default: reg_rdata = {4'b0, key_ok && !secure, !secure, active, pend};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; page_q <= '0; page_arm <= 1'b0; mass_en <= 1'b0;
      pwe <= 1'b0; defer_en <= 1'b0; key_q <= '0;
      active <= 1'b0; pend <= 1'b0; fired <= 1'b0; eng_busy_q <= 1'b0;
      pend_addr <= '0; pend_data <= '0;
      fl_start <= 1'b0; fl_op <= '0; fl_addr <= '0; fl_data <= '0;
    end else begin
      eng_busy_q <= eng_busy;
      fl_start   <= rel || do_er || do_pg;
      if (wr_cmd) cmd_q <= reg_wdata;
      if (wr_page) begin page_q <= reg_wdata[PW-1:0]; page_arm <= 1'b1; end
      if (wr_ctl) begin
        mass_en  <= reg_wdata[0];
        defer_en <= reg_wdata[2];
        key_q    <= reg_wdata[7:4];
      end
      if (st_valid && pwe) pwe <= 1'b0;
      else if (wr_ctl && !irq_en) pwe <= reg_wdata[1];
      if (do_er) begin page_arm <= 1'b0; mass_en <= 1'b0; end
      if (fl_done) active <= 1'b0;
      if (rel || do_er || do_pg) active <= 1'b1;
      if (rel) begin
        fl_op <= OP_PROG; fl_addr <= pend_addr; fl_data <= pend_data;
        pend <= 1'b0; fired <= 1'b0;
      end else if (pg_er) begin
        fl_op <= OP_PAGE; fl_addr <= AW'(page_q) << PAGE_LSB; fl_data <= '1;
      end else if (ms_er) begin
        fl_op <= OP_MASS; fl_addr <= '0; fl_data <= '1;
      end else if (imm) begin
        fl_op <= OP_PROG; fl_addr <= st_addr; fl_data <= st_data;
      end
      if (pend && fell && active) fired <= 1'b1;
      if (to_buf && !pend) begin
        pend <= 1'b1; pend_addr <= st_addr; pend_data <= st_data;
      end
    end
  end

  assert_one_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fl_done) |=> !fl_start);
  assert_busy_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |-> active);
  assert_erase_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_start && fl_op != OP_PROG) |-> $past(key_q) == KEYV);
  assert_mass_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_start && fl_op == OP_MASS) |-> $past(mass_en && dbg_en));
  assert_page_spent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_start && fl_op == OP_PAGE) |-> ($past(page_arm) && !page_arm));
  assert_pwe_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en |=> !$rose(pwe));
  assert_hold_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && st_valid && !rel) |=> (pend && $stable(pend_addr) && $stable(pend_data)));
endmodule

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [1:0] reg_addr = 0; logic [7:0] reg_wdata = 0; logic [7:0] reg_rdata;
  logic st_valid = 0; logic [15:0] st_addr = 0; logic [7:0] st_data = 0;
  logic irq_en = 0, dbg_en = 0, secure = 0, eng_en = 0, eng_busy = 0;
  logic fl_start; logic [1:0] fl_op; logic [15:0] fl_addr; logic [7:0] fl_data;
  logic fl_done = 0;
  int vecs = 0, errs = 0, lat = 3, cnt = 0;
  bit finished = 0;
  logic [25:0] eq[$];
  string etag[$];

  always #5 clk = ~clk;

  flash_cmd_ctrl u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .irq_en(irq_en), .dbg_en(dbg_en), .secure(secure), .eng_en(eng_en),
    .eng_busy(eng_busy), .fl_start(fl_start), .fl_op(fl_op), .fl_addr(fl_addr),
    .fl_data(fl_data), .fl_done(fl_done));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_op(logic [1:0] op, logic [15:0] a, logic [7:0] d, string tag);
    eq.push_back({op, a, d});
    etag.push_back(tag);
  endtask

  // flash model: done pulse lat cycles after start
  always @(negedge clk) begin
    fl_done <= 1'b0;
    if (fl_start) cnt <= lat;
    else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) fl_done <= 1'b1;
    end
  end

  // monitor: compare each start against the scoreboard
  always @(negedge clk) begin
    if (rst_n && fl_start) begin
      if (eq.size() == 0) begin
        vecs++; errs++;
        $display("FAIL R3/R4/R5/R9/R10 unexpected op actual=%h expected=none", {fl_op, fl_addr, fl_data});
      end else begin
        logic [25:0] e;
        string t;
        e = eq.pop_front();
        t = etag.pop_front();
        chk(t, {6'b0, fl_op, fl_addr, fl_data}, {6'b0, e});
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic store(logic [15:0] a, logic [7:0] d);
    @(negedge clk); st_valid = 1; st_addr = a; st_data = d;
    @(negedge clk); st_valid = 0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(tag, {24'b0, reg_rdata}, {24'b0, exp});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vecs++; errs++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    rd(3, 8'h04, "R10 reset status");
    rd(0, 8'h00, "R3 reset command");
    rd(2, 8'h00, "R6 reset control");
    // R5: locked key blocks page erase
    wr(1, 8'd5); wr(0, 8'h55); idle(6);
    wr(2, 8'h20);
    rd(3, 8'h0C, "R10 unlocked status");
    // R1: page erase
    expect_op(2'd1, 16'h1400, 8'hFF, "R1 page erase page 5");
    wr(0, 8'h55); idle(6);
    // R4: arming spent
    wr(0, 8'h55); idle(6);
    // R3: other value ignored, read back
    wr(0, 8'h12); idle(6);
    rd(0, 8'h12, "R3 command readback");
    // R2: mass erase needs dbg_en
    wr(2, 8'h21); wr(0, 8'hAA); idle(6);
    dbg_en = 1;
    expect_op(2'd2, 16'h0000, 8'hFF, "R2 mass erase");
    wr(0, 8'hAA); idle(6);
    rd(2, 8'h20, "R4 mass enable spent");
    // R10: busy, erase ignored while busy
    lat = 12;
    expect_op(2'd1, 16'h1C00, 8'hFF, "R1 page erase page 7");
    wr(1, 8'd7); wr(0, 8'h55);
    rd(3, 8'h0E, "R10 busy status");
    wr(1, 8'd9); wr(0, 8'h55); idle(16);
    lat = 3;
    expect_op(2'd1, 16'h2400, 8'hFF, "R10 erase after busy page 9");
    wr(0, 8'h55); idle(6);
    // R6: program
    wr(2, 8'h22);
    expect_op(2'd3, 16'h1234, 8'hA5, "R6 program byte");
    store(16'h1234, 8'hA5); idle(6);
    rd(2, 8'h20, "R6 program enable self-clear");
    store(16'h5555, 8'h11); idle(6);
    // R7: irq lock
    irq_en = 1; wr(2, 8'h22);
    rd(2, 8'h20, "R7 program enable locked");
    irq_en = 0;
    // R8/R9: deferred
    eng_en = 1; eng_busy = 1;
    wr(2, 8'h26); store(16'h0100, 8'h3C); idle(6);
    rd(3, 8'h0D, "R8 pending status");
    wr(2, 8'h26); store(16'h0200, 8'h77); idle(6);
    rd(3, 8'h0D, "R9 still pending");
    chk("R8 held until busy falls", eq.size(), 0);
    expect_op(2'd3, 16'h0100, 8'h3C, "R8/R9 deferred release");
    @(negedge clk); eng_busy = 0; idle(6);
    rd(3, 8'h0C, "R8 pending cleared");
    eng_en = 0;
    wr(2, 8'h26);
    expect_op(2'd3, 16'h0300, 8'h99, "R8 immediate when engine off");
    store(16'h0300, 8'h99); idle(6);
    rd(2, 8'h24, "R6 control after stores");
    secure = 1;
    rd(3, 8'h00, "R10 secure status");
    chk("R11 scoreboard drained", eq.size(), 0);
    finished = 1;
    summary();
  end
endmodule